// File: doc/BRIEF.md
# GPIO Bank with Grouped Interrupt Summary

This block is a bank of general-purpose pins behind a simple register bus. Every pin owns one 32-bit word, and that word does four jobs. It drives the pin's output value and output enable. It reports the synchronized input level. It sets up interrupt detection, which can be level or edge sensitive and can watch the high state, the low state or both edges. It also holds a sticky per-pin interrupt status.

Pending interrupts are gathered into a 64-bit summary. Each summary bit covers four neighbouring pins. The summary raises one shared interrupt line. Software handles an interrupt in four steps:

1. Read the summary.
2. Visit the pins in each flagged group.
3. Clear each pin's status by writing its word back.
4. Write the end-of-interrupt bit in the master control word.

The pin count is a parameter, with a default of 16. The pin slot at word index 63 (byte offset 0xFC) is never a pin, because that offset is the master control word.

Top module: `gpio_group_irq`

## Requirements
- R1: Pin p's word sits at byte offset 4·p. Bits 8, 9, 10, 11, 12, 22 and 23 are read/write and read back as written. Every other bit reads zero, except bit 16 (input level) and bit 28 (status).
- R2: `pad_out[p]` follows bit 22 and `pad_oe[p]` follows bit 23 of pin p's word, starting from the clock edge that performs the write.
- R3: Bit 16 of a pin word shows `pad_in[p]` through a two-flop synchronizer. A change at the pad appears after the second rising clock edge.
- R4: In edge mode (bit 8 = 0) with detection on, status bit 28 sets on the third rising edge after the pad changes. It watches the rising edge when bit 9 = 0 and the falling edge when bit 9 = 1. When bit 10 = 1 it watches both edges.
- R5: In level mode (bit 8 = 1), status is set on every cycle in which the synchronized input is at the active level: high when bit 9 = 0, low when bit 9 = 1. Bit 10 has no effect in level mode. A clear while the level is still active leaves the status set.
- R6: Writing a pin word with bit 28 = 1 clears that pin's status. Writing it with bit 28 = 0 leaves the status unchanged. A new detection in the same cycle wins over the clear.
- R7: Status can only set while bit 11 (detect enable) is 1. Bit 12 (route) decides whether a set status counts as pending for the summary.
- R8: Summary bit i is the OR of the pending state of pins 4i to 4i+3. The summary reads as its low word at offset 0x2F8 and its high word at 0x2FC.
- R9: `irq` goes high one rising edge after any pin's pending state goes from 0 to 1. It stays high until a write to offset 0xFC with bit 29 = 1. After that write it stays low, even while old pending interrupts remain, until some pin's pending state rises again.
- R10: The following reads return zero:
  - misaligned addresses;
  - offsets with no pin behind them;
  - offset 0xFC.
  Writes to misaligned or unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | NUM_PINS | Asynchronous pin inputs |
| pad_out | output | NUM_PINS | Pin output values |
| pad_oe | output | NUM_PINS | Pin output enables |
| irq | output | 1 | Shared interrupt request |

## Verification
Each result has a fixed latency:

| Result | Due |
|--------|-----|
| Output drive | Immediately after the writing edge |
| Synchronized input bit | Two rising edges after a pad change |
| Edge status | Three rising edges after a pad change |
| Interrupt line | Four rising edges after a pad change |
| Level status after a configuration write | One edge after that write |

The bench changes pads and bus inputs only at falling edges, then counts whole cycles before it reads. It checks the value one cycle before each due point as well as at it, so a stage added or removed in the pipeline is detected. Bus reads are combinational and are sampled 1 ns after a falling edge.

// File: rtl/gpio_grp_pkg.sv
package gpio_grp_pkg;
   // bit positions inside a pin word
   localparam int BIT_LEVEL = 8;
   localparam int BIT_ACTLO = 9;
   localparam int BIT_BOTH  = 10;
   localparam int BIT_DETEN = 11;
   localparam int BIT_ROUTE = 12;
   localparam int BIT_IN    = 16;
   localparam int BIT_OUTV  = 22;
   localparam int BIT_OE    = 23;
   localparam int BIT_STS   = 28;
   // bit position inside the master control word
   localparam int BIT_EOI   = 29;

   localparam int GROUP_PINS   = 4;
   localparam int MAX_PINS     = 184;
   localparam int SUM_W        = 64;
   localparam int MASTER_WORD  = 63;   // byte offset 0xFC
   localparam int SUM_LO_WORD  = 190;  // byte offset 0x2F8
   localparam int SUM_HI_WORD  = 191;  // byte offset 0x2FC
   localparam int MIN_ADDR_W   = 10;

   typedef struct packed {
      logic oe;
      logic outv;
      logic route;
      logic deten;
      logic both;
      logic actlo;
      logic level;
   } pin_cfg_t;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_in_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
   import gpio_grp_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pad_in,
   input  logic       wr_en,
   input  pin_cfg_t   wr_cfg,
   input  logic       wr_clr,
   output logic [31:0] rd_word,
   output logic       pad_out,
   output logic       pad_oe,
   output logic       pending
);
   pin_cfg_t cfg_q;
   logic     s_in, s_d, sts_q;
   logic     rise, fall, edge_hit, lvl_hit, hit;

   gpio_in_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (s_in)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_d   <= 1'b0;
         cfg_q <= '0;
      end else begin
         s_d <= s_in;
         if (wr_en) cfg_q <= wr_cfg;
      end
   end

   always_comb begin
      rise     = s_in & ~s_d;
      fall     = ~s_in & s_d;
      edge_hit = cfg_q.both ? (rise | fall) : (cfg_q.actlo ? fall : rise);
      lvl_hit  = cfg_q.actlo ? ~s_in : s_in;
      hit      = cfg_q.deten & (cfg_q.level ? lvl_hit : edge_hit);
   end

   // a fresh detection wins over a software clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               sts_q <= 1'b0;
      else if (hit)             sts_q <= 1'b1;
      else if (wr_en && wr_clr) sts_q <= 1'b0;
   end

   always_comb begin
      rd_word            = '0;
      rd_word[BIT_LEVEL] = cfg_q.level;
      rd_word[BIT_ACTLO] = cfg_q.actlo;
      rd_word[BIT_BOTH]  = cfg_q.both;
      rd_word[BIT_DETEN] = cfg_q.deten;
      rd_word[BIT_ROUTE] = cfg_q.route;
      rd_word[BIT_IN]    = s_in;
      rd_word[BIT_OUTV]  = cfg_q.outv;
      rd_word[BIT_OE]    = cfg_q.oe;
      rd_word[BIT_STS]   = sts_q;
   end

   assign pad_out = cfg_q.outv;
   assign pad_oe  = cfg_q.oe;
   assign pending = sts_q & cfg_q.route;

   p_rise_sets_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q.deten && !cfg_q.level && !cfg_q.actlo && !cfg_q.both && s_in && !s_d) |=> sts_q);

   p_level_holds_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q.deten && cfg_q.level && (s_in != cfg_q.actlo)) |=> sts_q);

   p_clear_when_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_clr && !cfg_q.deten) |=> !sts_q);

   p_no_set_when_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_q.deten && !sts_q) |=> !sts_q);
endmodule

// File: rtl/gpio_irq_summary.sv
module gpio_irq_summary
   import gpio_grp_pkg::*;
#(
   parameter int NUM_PINS = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pend,
   input  logic                eoi,
   output logic [SUM_W-1:0]    summary,
   output logic                irq
);
   localparam int NGRP = (NUM_PINS + GROUP_PINS - 1) / GROUP_PINS;
   localparam int PADW = NGRP * GROUP_PINS;

   if (NGRP > SUM_W) begin : g_bad_groups
      $error("gpio_irq_summary: too many pin groups for the summary");
   end

   logic [PADW-1:0]     pend_pad;
   logic [NUM_PINS-1:0] pend_q;
   logic                new_pend, irq_q;

   assign pend_pad = PADW'(pend);

   for (genvar g = 0; g < SUM_W; g++) begin : g_sum
      if (g < NGRP) begin : g_used
         assign summary[g] = |pend_pad[g*GROUP_PINS +: GROUP_PINS];
      end else begin : g_unused
         assign summary[g] = 1'b0;
      end
   end

   assign new_pend = |(pend & ~pend_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         irq_q  <= 1'b0;
      end else begin
         pend_q <= pend;
         if (new_pend) irq_q <= 1'b1;
         else if (eoi) irq_q <= 1'b0;
      end
   end

   assign irq = irq_q;

   p_eoi_drops_line_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && !new_pend) |=> !irq_q);

   p_line_held_until_eoi_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q && !eoi) |=> irq_q);

   p_new_pending_raises_r9: assert property (@(posedge clk) disable iff (!rst_n)
      new_pend |=> irq_q);
endmodule

// File: rtl/gpio_group_irq.sv
module gpio_group_irq
   import gpio_grp_pkg::*;
#(
   parameter int NUM_PINS    = 16,
   parameter int ADDR_W      = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_we,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe,
   output logic                irq
);
   localparam int IDX_W = ADDR_W - 2;

   if (NUM_PINS < 1 || NUM_PINS > MAX_PINS) begin : g_bad_pins
      $error("gpio_group_irq: NUM_PINS out of range");
   end
   if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr
      $error("gpio_group_irq: ADDR_W too small for the summary words");
   end

   logic [IDX_W-1:0]    word_idx;
   logic                addr_ok, wr_ok, eoi;
   pin_cfg_t            wr_cfg;
   logic                wr_clr;
   logic [31:0]         pin_rd [NUM_PINS];
   logic [NUM_PINS-1:0] pend;
   logic [SUM_W-1:0]    summary;
   logic                unused_wdata;

   assign word_idx = bus_addr[ADDR_W-1:2];
   assign addr_ok  = (bus_addr[1:0] == 2'b00);
   assign wr_ok    = bus_we && addr_ok;
   assign eoi      = wr_ok && (word_idx == IDX_W'(MASTER_WORD)) && bus_wdata[BIT_EOI];

   always_comb begin
      wr_cfg.level = bus_wdata[BIT_LEVEL];
      wr_cfg.actlo = bus_wdata[BIT_ACTLO];
      wr_cfg.both  = bus_wdata[BIT_BOTH];
      wr_cfg.deten = bus_wdata[BIT_DETEN];
      wr_cfg.route = bus_wdata[BIT_ROUTE];
      wr_cfg.outv  = bus_wdata[BIT_OUTV];
      wr_cfg.oe    = bus_wdata[BIT_OE];
      wr_clr       = bus_wdata[BIT_STS];
   end

   assign unused_wdata = ^{bus_wdata[31:30], bus_wdata[27:24], bus_wdata[21:13], bus_wdata[7:0]};

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      if (p == MASTER_WORD) begin : g_reserved
         assign pin_rd[p]  = '0;
         assign pad_out[p] = 1'b0;
         assign pad_oe[p]  = 1'b0;
         assign pend[p]    = 1'b0;
      end else begin : g_cell
         gpio_pin_cell #(.SYNC_STAGES(SYNC_STAGES)) i_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .pad_in  (pad_in[p]),
            .wr_en   (wr_ok && (word_idx == IDX_W'(p))),
            .wr_cfg  (wr_cfg),
            .wr_clr  (wr_clr),
            .rd_word (pin_rd[p]),
            .pad_out (pad_out[p]),
            .pad_oe  (pad_oe[p]),
            .pending (pend[p])
         );
      end
   end

   gpio_irq_summary #(.NUM_PINS(NUM_PINS)) i_summary (
      .clk     (clk),
      .rst_n   (rst_n),
      .pend    (pend),
      .eoi     (eoi),
      .summary (summary),
      .irq     (irq)
   );

   always_comb begin
      bus_rdata = '0;
      if (addr_ok) begin
         for (int p = 0; p < NUM_PINS; p++) begin
            if (word_idx == IDX_W'(p)) bus_rdata = pin_rd[p];
         end
         if (word_idx == IDX_W'(SUM_LO_WORD)) bus_rdata = summary[31:0];
         if (word_idx == IDX_W'(SUM_HI_WORD)) bus_rdata = summary[63:32];
      end
   end

   p_unmapped_reads_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr[1:0] != 2'b00) |-> (bus_rdata == 32'h0));
endmodule

// File: tb/test_gpio_group_irq.sv
module test_gpio_group_irq;
   localparam logic [31:0] B_LVL   = 32'h0000_0100;
   localparam logic [31:0] B_ACTLO = 32'h0000_0200;
   localparam logic [31:0] B_BOTH  = 32'h0000_0400;
   localparam logic [31:0] B_DET   = 32'h0000_0800;
   localparam logic [31:0] B_ROUTE = 32'h0000_1000;
   localparam logic [31:0] B_IN    = 32'h0001_0000;
   localparam logic [31:0] B_OUTV  = 32'h0040_0000;
   localparam logic [31:0] B_OE    = 32'h0080_0000;
   localparam logic [31:0] B_STS   = 32'h1000_0000;
   localparam logic [31:0] B_EOI   = 32'h2000_0000;
   localparam logic [9:0]  A_MASTER = 10'h0FC;
   localparam logic [9:0]  A_SUMLO  = 10'h2F8;
   localparam logic [9:0]  A_SUMHI  = 10'h2FC;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [9:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [15:0] pad_in = '0;
   logic [15:0] pad_out, pad_oe;
   logic        irq;
   int          checks = 0;
   int          fails = 0;

   always #4 clk = ~clk;

   gpio_group_irq i_gpio_group_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pad_in    (pad_in),
      .pad_out   (pad_out),
      .pad_oe    (pad_oe),
      .irq       (irq)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic nclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [9:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [9:0] a, output logic [31:0] d);
      bus_addr = a; bus_we = 1'b0;
      #1 d = bus_rdata;
   endtask

   task automatic rdchk(input string tag, input logic [9:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      chk(tag, v, exp);
   endtask

   task automatic t_reset;
      chk("R9 reset irq", {31'b0, irq}, 32'h0);
      chk("R2 reset oe", {16'b0, pad_oe}, 32'h0);
      rdchk("R1 reset pin0", 10'h000, 32'h0);
      rdchk("R8 reset summary", A_SUMLO, 32'h0);
   endtask

   task automatic t_cfg_rw;
      wr(10'h008, 32'hFFFF_FDFF);
      rdchk("R1 pin2 readback", 10'h008, 32'h00C0_1D00);
      chk("R2 pin2 out", {16'b0, pad_out}, 32'h0004);
      wr(10'h008, 32'h0);
      rdchk("R1 pin2 zero", 10'h008, 32'h0);
   endtask

   task automatic t_output;
      wr(10'h004, B_OE | B_OUTV);
      chk("R2 out high", {16'b0, pad_out}, 32'h0002);
      chk("R2 oe high", {16'b0, pad_oe}, 32'h0002);
      wr(10'h004, B_OE);
      chk("R2 out low", {16'b0, pad_out}, 32'h0000);
      chk("R2 oe kept", {16'b0, pad_oe}, 32'h0002);
   endtask

   task automatic t_input;
      pad_in[3] = 1'b1;
      nclk(1);
      rdchk("R3 one edge", 10'h00C, 32'h0);
      nclk(1);
      rdchk("R3 two edges", 10'h00C, B_IN);
   endtask

   task automatic t_edge;
      logic [31:0] c;
      c = B_DET | B_ROUTE;
      wr(10'h010, c);
      pad_in[4] = 1'b1;
      nclk(2);
      rdchk("R4 not yet", 10'h010, c | B_IN);
      nclk(1);
      rdchk("R4 rise sets", 10'h010, c | B_IN | B_STS);
      chk("R9 irq not yet", {31'b0, irq}, 32'h0);
      rdchk("R8 group1", A_SUMLO, 32'h2);
      nclk(1);
      chk("R9 irq up", {31'b0, irq}, 32'h1);
      wr(10'h010, c);
      rdchk("R6 zero keeps", 10'h010, c | B_IN | B_STS);
      wr(10'h010, c | B_STS);
      rdchk("R6 clear", 10'h010, c | B_IN);
      rdchk("R8 cleared", A_SUMLO, 32'h0);
      chk("R9 latched", {31'b0, irq}, 32'h1);
      pad_in[4] = 1'b0;
      nclk(4);
      rdchk("R4 fall ignored", 10'h010, c);
      c = B_DET | B_ROUTE | B_ACTLO;
      wr(10'h010, c);
      pad_in[4] = 1'b1;
      nclk(4);
      rdchk("R4 actlo rise ignored", 10'h010, c | B_IN);
      pad_in[4] = 1'b0;
      nclk(3);
      rdchk("R4 actlo fall sets", 10'h010, c | B_STS);
      wr(10'h010, c | B_STS);
      c = B_DET | B_ROUTE | B_BOTH;
      wr(10'h010, c);
      pad_in[4] = 1'b1;
      nclk(3);
      rdchk("R4 both rise", 10'h010, c | B_IN | B_STS);
      wr(10'h010, c | B_STS);
      pad_in[4] = 1'b0;
      nclk(3);
      rdchk("R4 both fall", 10'h010, c | B_STS);
      wr(10'h010, c | B_STS);
      wr(A_MASTER, B_EOI);
      chk("R9 eoi drops", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_level;
      logic [31:0] c;
      c = B_LVL | B_DET | B_ROUTE;
      wr(10'h018, c);
      rdchk("R5 idle low", 10'h018, c);
      pad_in[6] = 1'b1;
      nclk(3);
      rdchk("R5 high sets", 10'h018, c | B_IN | B_STS);
      wr(10'h018, c | B_STS);
      rdchk("R5 reasserts", 10'h018, c | B_IN | B_STS);
      pad_in[6] = 1'b0;
      nclk(3);
      wr(10'h018, c | B_STS);
      rdchk("R5 cleared", 10'h018, c);
      c = B_LVL | B_ACTLO | B_DET | B_ROUTE;
      wr(10'h018, c);
      rdchk("R5 actlo not yet", 10'h018, c);
      nclk(1);
      rdchk("R5 actlo sets", 10'h018, c | B_STS);
      wr(10'h018, B_LVL | B_ACTLO | B_ROUTE);
      c = B_LVL | B_BOTH | B_DET | B_ROUTE;
      wr(10'h018, c | B_STS);
      nclk(2);
      rdchk("R5 both ignored", 10'h018, c);
      wr(A_MASTER, B_EOI);
   endtask

   task automatic t_enable;
      wr(10'h020, B_ROUTE);
      pad_in[8] = 1'b1;
      nclk(4);
      rdchk("R7 disabled", 10'h020, B_ROUTE | B_IN);
      wr(10'h024, B_DET);
      pad_in[9] = 1'b1;
      nclk(4);
      rdchk("R7 unrouted sets", 10'h024, B_DET | B_IN | B_STS);
      rdchk("R7 unrouted summary", A_SUMLO, 32'h0);
      chk("R7 unrouted irq", {31'b0, irq}, 32'h0);
      wr(10'h024, B_DET | B_STS);
   endtask

   task automatic t_summary;
      wr(10'h014, B_DET | B_ROUTE);
      wr(10'h034, B_DET | B_ROUTE);
      pad_in[5] = 1'b1;
      pad_in[13] = 1'b1;
      nclk(3);
      rdchk("R8 two groups", A_SUMLO, 32'hA);
      rdchk("R8 high word", A_SUMHI, 32'h0);
      wr(10'h014, B_DET | B_ROUTE | B_STS);
      wr(10'h034, B_DET | B_ROUTE | B_STS);
      rdchk("R8 emptied", A_SUMLO, 32'h0);
      wr(A_MASTER, B_EOI);
   endtask

   task automatic t_irq;
      chk("R9 idle", {31'b0, irq}, 32'h0);
      pad_in[13] = 1'b0;
      nclk(3);
      pad_in[13] = 1'b1;
      nclk(3);
      chk("R9 three edges", {31'b0, irq}, 32'h0);
      nclk(1);
      chk("R9 four edges", {31'b0, irq}, 32'h1);
      wr(10'h034, B_DET | B_ROUTE | B_STS);
      chk("R9 held after clear", {31'b0, irq}, 32'h1);
      wr(A_MASTER, B_EOI);
      chk("R9 eoi low", {31'b0, irq}, 32'h0);
      pad_in[5] = 1'b0;
      nclk(3);
      pad_in[5] = 1'b1;
      nclk(4);
      chk("R9 pin5 raises", {31'b0, irq}, 32'h1);
      wr(A_MASTER, B_EOI);
      nclk(5);
      chk("R9 stays low with old pending", {31'b0, irq}, 32'h0);
      rdchk("R9 old pending kept", A_SUMLO, 32'h2);
      pad_in[13] = 1'b0;
      nclk(3);
      pad_in[13] = 1'b1;
      nclk(4);
      chk("R9 new pending raises", {31'b0, irq}, 32'h1);
   endtask

   task automatic t_unmapped;
      rdchk("R10 unmapped read", 10'h040, 32'h0);
      wr(10'h040, 32'hFFFF_FFFF);
      rdchk("R10 unmapped write", 10'h040, 32'h0);
      rdchk("R10 neighbour intact", 10'h008, 32'h0);
      rdchk("R10 master reads zero", A_MASTER, 32'h0);
      rdchk("R10 misaligned read", 10'h011, 32'h0);
      wr(10'h019, 32'hFFFF_FFFF);
      rdchk("R10 misaligned write", 10'h018, B_LVL | B_BOTH | B_DET | B_ROUTE);
   endtask

   initial begin
      nclk(3);
      rst_n = 1'b1;
      nclk(1);
      t_reset();
      t_cfg_rw();
      t_output();
      t_input();
      t_edge();
      t_level();
      t_enable();
      t_summary();
      t_irq();
      t_unmapped();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule